// File: doc/BRIEF.md
# Two-Wire Bus Read Master

This block is the controller side of a two-wire serial bus (SCL and SDA, both open-drain) for the read direction only. A single-cycle command gives it a 7-bit target address, a byte count and two request bits, one to begin and one to end. The engine produces the START pattern and shifts out the address with the read bit set. It then shifts in as many bytes as were asked for and finishes with a STOP.

Each byte lands in one holding register. A ready flag marks the register as full, and a host or a receive DMA channel uses that flag as its request. A remaining-byte counter decides two things: whether the master pulls SDA low in the ninth clock of a byte, and when the STOP is sent. A count of zero gives an address-only read.

If the holding register has not been emptied when the next byte would start, the engine holds SCL low until it is read. The bit rate comes from a run-time divider input. The two line outputs are low-drive enables for external open-drain pads. The SDA pad value comes back on an input.

Top module: `i2c_rd_master`

## Requirements
- R1: After reset `idle` is 1, `rx_ready` and `nack_err` are 0, and both line enables `scl_oe` and `sda_oe` are 0 (lines released). While `idle` is 1 both enables stay 0.
- R2: A command is taken only while `idle` is 1 and `cmd_start` is 1. A pulse on `cmd_valid` with `cmd_start` at 0 leaves the block idle and the bus untouched. Once a command is taken, `idle` is 0 from the next cycle.
- R3: The address byte is `{cmd_addr, 1'b1}`, sent most significant bit first. During address and data bits, SDA changes only while SCL is held low.
- R4: Data bytes are taken in most significant bit first, one bit per SCL high phase. Each finished byte appears on `rx_data` with `rx_ready` at 1.
- R5: In the ninth clock of every received byte except the last, the master drives SDA low (acknowledge). For the last byte it leaves SDA released.
- R6: A command for N bytes (N at least 1) produces exactly N bytes on `rx_data` and 10+9N SCL rising edges between START and STOP. `idle` returns to 1 once the STOP has completed.
- R7: A command with a byte count of 0 and STOP requested gives START, the address byte with its acknowledge clock, then STOP: 10 SCL rising edges and no byte delivered.
- R8: If `rx_ready` is still 1 when the next byte would begin, SCL is held low and `rx_data` holds its value until the register is read.
- R9: A cycle with `rx_read` at 1 while `rx_ready` is 1 clears `rx_ready` at that clock edge.
- R10: If the address byte is not acknowledged (SDA high in its ninth clock), `nack_err` becomes 1, a STOP follows and no data byte is delivered. `nack_err` returns to 0 when the next command is taken.
- R11: With `cmd_stop` at 0, after the last byte the engine keeps SCL low and `idle` at 0. A later `cmd_valid` with `cmd_stop` at 1 then issues the STOP and the block returns to idle.
- R12: Each SCL high phase lasts 2*(`clk_div`+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Quarter-bit length minus one, in clock cycles |
| cmd_valid | input | 1 | Command strobe |
| cmd_start | input | 1 | Begin a read transaction |
| cmd_stop | input | 1 | End with STOP (or close a parked bus) |
| cmd_addr | input | 7 | Target address |
| cmd_nbytes | input | CNT_W | Number of bytes to read |
| rx_read | input | 1 | Holding register read strobe |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | Holding register full; DMA request |
| idle | output | 1 | No transaction in progress, bus released |
| nack_err | output | 1 | Address was not acknowledged |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA pad value |

## Verification
Most sequencer faults change the number of SCL rising edges or the acknowledge pattern in a single transaction. The slave model counts both, so such a fault is seen at the STOP of the first transaction it touches. A bad remaining-byte counter shows up at once as a wrong ninth-clock level or a wrong byte total. A bit-position fault shows up at once as a wrong address seen by the slave or a wrong `rx_data` value. Holding-register faults appear within one byte time: either SCL keeps toggling while `rx_ready` is 1, or `rx_data` changes under the reader.

// File: rtl/i2c_rd_pkg.sv
`timescale 1ns/1ps
package i2c_rd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_ADDR,
      ST_RXB,
      ST_PARK,
      ST_STOP
   } rd_state_e;

   // one bit slot = four quarter phases; slot 8 is the ninth (acknowledge) clock
   localparam logic [3:0] ACK_SLOT  = 4'd8;
   localparam logic [3:0] LAST_BIT  = 4'd7;
   localparam logic [1:0] PH_SAMPLE = 2'd2;
   localparam logic [1:0] PH_LAST   = 2'd3;

   typedef struct packed {
      logic scl_low;
      logic sda_low;
      logic data_ph;
   } line_drv_t;

endpackage

// File: rtl/i2c_rd_clkdiv.sv
`timescale 1ns/1ps
module i2c_rd_clkdiv #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;
   logic             wrap;

   assign wrap = (cnt == div);
   assign tick = wrap && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (clr || wrap)  cnt <= '0;
      else                   cnt <= cnt + DIV_W'(1);
   end

endmodule

// File: rtl/i2c_rd_rxhold.sv
`timescale 1ns/1ps
module i2c_rd_rxhold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              rd,
   output logic              full,
   output logic [DATA_W-1:0] data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (load) begin
         full <= 1'b1;
         data <= load_data;
      end else if (rd) begin
         full <= 1'b0;
      end
   end

endmodule

// File: rtl/i2c_rd_seq.sv
`timescale 1ns/1ps
module i2c_rd_seq
   import i2c_rd_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cmd_valid,
   input  logic             cmd_start,
   input  logic             cmd_stop,
   input  logic [6:0]       cmd_addr,
   input  logic [CNT_W-1:0] cmd_nbytes,
   input  logic             sda_in,
   input  logic             rx_full,
   output logic             div_clr,
   output logic             rx_load,
   output logic [7:0]       rx_byte,
   output line_drv_t        drv,
   output logic             idle,
   output logic             nack_err
);

   rd_state_e        st;
   logic [3:0]       slot;
   logic [1:0]       ph;
   logic [CNT_W-1:0] remain;
   logic             stop_req;
   logic [7:0]       abyte;
   logic [7:0]       shreg;
   logic             addr_nak;

   logic      stall, adv, samp, accept, park_stop;
   rd_state_e tail_state;

   // holding register still full at the start of a new byte: freeze in SCL low
   assign stall     = (st == ST_RXB) && (slot == 4'd0) && (ph == 2'd0) && rx_full;
   assign adv       = tick && !stall;
   assign samp      = adv && (ph == PH_SAMPLE);
   assign accept    = (st == ST_IDLE) && cmd_valid && cmd_start;
   assign park_stop = (st == ST_PARK) && cmd_valid && cmd_stop;
   assign div_clr   = (st == ST_IDLE) || (st == ST_PARK);
   assign idle      = (st == ST_IDLE);

   assign rx_load = samp && (st == ST_RXB) && (slot == LAST_BIT);
   assign rx_byte = {shreg[6:0], sda_in};

   always_comb begin
      if (remain != '0)  tail_state = ST_RXB;
      else if (stop_req) tail_state = ST_STOP;
      else               tail_state = ST_PARK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         slot     <= '0;
         ph       <= '0;
         remain   <= '0;
         stop_req <= 1'b0;
         abyte    <= '0;
         shreg    <= '0;
         addr_nak <= 1'b0;
         nack_err <= 1'b0;
      end else if (accept) begin
         st       <= ST_START;
         slot     <= '0;
         ph       <= '0;
         abyte    <= {cmd_addr, 1'b1};
         remain   <= cmd_nbytes;
         stop_req <= cmd_stop;
         nack_err <= 1'b0;
      end else if (park_stop) begin
         st <= ST_STOP;
         ph <= '0;
      end else if (adv) begin
         ph <= ph + 2'd1;
         if (samp) begin
            if (st == ST_ADDR && slot == ACK_SLOT) addr_nak <= sda_in;
            if (st == ST_RXB && slot != ACK_SLOT)  shreg    <= {shreg[6:0], sda_in};
            if (rx_load)                           remain   <= remain - CNT_W'(1);
         end
         if (ph == PH_LAST) begin
            unique case (st)
               ST_START: begin
                  st   <= ST_ADDR;
                  slot <= '0;
               end
               ST_ADDR: begin
                  if (slot == ACK_SLOT) begin
                     slot <= '0;
                     if (addr_nak) begin
                        nack_err <= 1'b1;
                        st       <= ST_STOP;
                     end else begin
                        st <= tail_state;
                     end
                  end else begin
                     slot <= slot + 4'd1;
                  end
               end
               ST_RXB: begin
                  if (slot == ACK_SLOT) begin
                     slot <= '0;
                     st   <= tail_state;
                  end else begin
                     slot <= slot + 4'd1;
                  end
               end
               ST_STOP: st <= ST_IDLE;
               default: ;
            endcase
         end
      end
   end

   // line drive: quarters 0,1 SCL low, quarters 2,3 SCL released
   always_comb begin
      drv = '0;
      unique case (st)
         ST_START: begin
            drv.sda_low = (ph != 2'd0);
            drv.scl_low = (ph == PH_LAST);
         end
         ST_ADDR: begin
            drv.scl_low = (ph < PH_SAMPLE);
            drv.sda_low = (slot != ACK_SLOT) && !abyte[3'd7 - slot[2:0]];
            drv.data_ph = 1'b1;
         end
         ST_RXB: begin
            drv.scl_low = (ph < PH_SAMPLE);
            drv.sda_low = (slot == ACK_SLOT) && (remain != '0);
            drv.data_ph = 1'b1;
         end
         ST_PARK: drv.scl_low = 1'b1;
         ST_STOP: begin
            drv.scl_low = (ph == 2'd0);
            drv.sda_low = (ph != PH_LAST);
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/i2c_rd_master.sv
`timescale 1ns/1ps
module i2c_rd_master
   import i2c_rd_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int DIV_W   = 12,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] clk_div,
   input  logic             cmd_valid,
   input  logic             cmd_start,
   input  logic             cmd_stop,
   input  logic [6:0]       cmd_addr,
   input  logic [CNT_W-1:0] cmd_nbytes,
   input  logic             rx_read,
   output logic [7:0]       rx_data,
   output logic             rx_ready,
   output logic             idle,
   output logic             nack_err,
   output logic             scl_oe,
   output logic             sda_oe,
   input  logic             sda_in
);

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must lie in 1..16");
   end
   if (DIV_W < 2 || DIV_W > 24) begin : g_bad_div
      $error("DIV_W must lie in 2..24");
   end

   logic       tick, div_clr, rx_load;
   logic [7:0] rx_byte;
   line_drv_t  drv_c, drv_q;
   logic       line_data_ph;

   i2c_rd_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (div_clr),
      .div   (clk_div),
      .tick  (tick)
   );

   i2c_rd_seq #(.CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .cmd_valid  (cmd_valid),
      .cmd_start  (cmd_start),
      .cmd_stop   (cmd_stop),
      .cmd_addr   (cmd_addr),
      .cmd_nbytes (cmd_nbytes),
      .sda_in     (sda_in),
      .rx_full    (rx_ready),
      .div_clr    (div_clr),
      .rx_load    (rx_load),
      .rx_byte    (rx_byte),
      .drv        (drv_c),
      .idle       (idle),
      .nack_err   (nack_err)
   );

   i2c_rd_rxhold #(.DATA_W(8)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (rx_load),
      .load_data (rx_byte),
      .rd        (rx_read),
      .full      (rx_ready),
      .data      (rx_data)
   );

   if (OUT_REG) begin : g_line_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) drv_q <= '0;
         else        drv_q <= drv_c;
      end
   end else begin : g_line_comb
      assign drv_q = drv_c;
   end

   assign scl_oe       = drv_q.scl_low;
   assign sda_oe       = drv_q.sda_low;
   assign line_data_ph = drv_q.data_ph;

endmodule

// File: rtl/i2c_rd_master_chk.sv
`timescale 1ns/1ps
module i2c_rd_master_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic       cmd_start,
   input logic       rx_read,
   input logic       rx_ready,
   input logic [7:0] rx_data,
   input logic       idle,
   input logic       nack_err,
   input logic       scl_oe,
   input logic       sda_oe,
   input logic       data_ph
);

   assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (!scl_oe && !sda_oe));

   assert_no_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && cmd_valid && !cmd_start) |=> idle);

   assert_sda_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_ph && $past(data_ph) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

   assert_hold_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready && !rx_read) |=> (rx_ready && $stable(rx_data)));

   assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready && rx_read) |=> !rx_ready);

   assert_nack_no_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (nack_err && !idle) |=> !$rose(rx_ready));

endmodule

bind i2c_rd_master i2c_rd_master_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_start (cmd_start),
   .rx_read   (rx_read),
   .rx_ready  (rx_ready),
   .rx_data   (rx_data),
   .idle      (idle),
   .nack_err  (nack_err),
   .scl_oe    (scl_oe),
   .sda_oe    (sda_oe),
   .data_ph   (line_data_ph)
);

// File: tb/i2c_rd_master_tb.sv
`timescale 1ns/1ps
module i2c_rd_master_tb;

   localparam int CNT_W = 8;
   localparam int DIV_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [DIV_W-1:0] clk_div = '0;
   logic             cmd_valid = 1'b0, cmd_start = 1'b0, cmd_stop = 1'b0;
   logic [6:0]       cmd_addr = '0;
   logic [CNT_W-1:0] cmd_nbytes = '0;
   logic             rx_read = 1'b0;
   logic [7:0]       rx_data;
   logic             rx_ready, idle, nack_err, scl_oe, sda_oe;
   logic             s_drive = 1'b0;
   logic             sda_in;

   always #2 clk = ~clk;

   assign sda_in = !(sda_oe || s_drive);

   i2c_rd_master #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
      .cmd_valid(cmd_valid), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
      .cmd_addr(cmd_addr), .cmd_nbytes(cmd_nbytes),
      .rx_read(rx_read), .rx_data(rx_data), .rx_ready(rx_ready),
      .idle(idle), .nack_err(nack_err),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
   );

   int tests = 0;
   int fails = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input logic [7:0] base, input int k);
      return base + 8'(k * 37);
   endfunction

   // ---------------- slave model ----------------
   logic [6:0] dev_addr = '0;
   bit         present = 1'b0;
   logic [7:0] tx_base = '0;
   bit         sp_scl = 1'b1, sp_sda = 1'b1, cs, cd;
   int         s_phase = 0;   // 0 idle,1 addr,2 sack,3 tx,4 mack,5 next,6 done
   int         s_bits, s_txi, s_k, s_rises, s_last_rises, s_acks, s_nacks;
   int         s_starts = 0, s_stops = 0, s_hi = 0, s_hi_last = 0;
   logic [7:0] s_addr_rx = '0, s_cur = '0;

   initial begin
      forever begin
         @(negedge clk);
         cs = !scl_oe;
         cd = !(sda_oe || s_drive);
         if (sp_scl && cs && sp_sda && !cd) begin
            s_starts++; s_phase = 1; s_bits = 0; s_rises = 0;
            s_acks = 0; s_nacks = 0; s_k = 0; s_drive = 1'b0;
         end else if (sp_scl && cs && !sp_sda && cd) begin
            s_stops++; s_last_rises = s_rises; s_phase = 0; s_drive = 1'b0;
         end else if (!sp_scl && cs) begin
            s_rises++; s_hi = 0;
            if (s_phase == 1) begin
               s_addr_rx = {s_addr_rx[6:0], cd}; s_bits++;
            end else if (s_phase == 4) begin
               if (!cd) begin s_acks++; s_phase = 5; end
               else begin s_nacks++; s_phase = 6; end
            end
         end else if (sp_scl && !cs) begin
            if (s_phase == 3) s_hi_last = s_hi;
            case (s_phase)
               1: if (s_bits == 8) begin
                     if (present && s_addr_rx == {dev_addr, 1'b1}) begin
                        s_drive = 1'b1; s_phase = 2;
                     end else s_phase = 6;
                  end
               2, 5: begin
                  s_cur = exp_byte(tx_base, s_k); s_k++;
                  s_txi = 7; s_drive = !s_cur[7]; s_phase = 3;
               end
               3: if (s_txi == 0) begin
                     s_drive = 1'b0; s_phase = 4;
                  end else begin
                     s_txi--; s_drive = !s_cur[s_txi];
                  end
               default: ;
            endcase
         end
         if (cs) s_hi++;
         sp_scl = cs;
         sp_sda = cd;
      end
   end

   // ---------------- transaction task ----------------
   task automatic run_read(input logic [6:0] a, input int n, input bit pres,
                           input bit stp, input int div, input int lag0);
      int got, wait_c, r_mid, n_exp;
      got = 0; wait_c = 0; r_mid = 0;
      n_exp = pres ? n : 0;
      dev_addr = a; present = pres; clk_div = DIV_W'(div);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_start = 1'b1; cmd_stop = stp;
      cmd_addr = a; cmd_nbytes = CNT_W'(n);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_start = 1'b0; cmd_stop = 1'b0;
      chk(!idle && !nack_err, "R2/R10 accept clears nack_err", int'(nack_err), 0);
      while (!(idle || (!stp && got == n_exp && wait_c >= 80))) begin
         @(negedge clk);
         if (rx_ready) begin
            chk(rx_data == exp_byte(tx_base, got), "R4 received byte",
                int'(rx_data), int'(exp_byte(tx_base, got)));
            if (got == 0 && lag0 > 0) begin
               repeat (lag0 / 2) @(negedge clk);
               r_mid = s_rises;
               repeat (lag0 / 2) @(negedge clk);
               chk(rx_ready && scl_oe && s_rises == r_mid &&
                   rx_data == exp_byte(tx_base, 0), "R8 SCL held while full",
                   s_rises, r_mid);
            end
            rx_read = 1'b1;
            @(negedge clk);
            rx_read = 1'b0;
            chk(!rx_ready, "R9 read clears ready", int'(rx_ready), 0);
            got++;
         end
         if (!stp && got == n_exp) wait_c++;
      end
      if (!stp) begin
         chk(!idle && scl_oe, "R11 parked with SCL low", int'(scl_oe), 1);
         @(negedge clk);
         cmd_valid = 1'b1; cmd_stop = 1'b1;
         @(negedge clk);
         cmd_valid = 1'b0; cmd_stop = 1'b0;
         while (!idle) @(negedge clk);
         chk(s_last_rises == 10 + 9 * n_exp, "R11 stop after park",
             s_last_rises, 10 + 9 * n_exp);
      end
      chk(got == n_exp, "R6 byte total", got, n_exp);
      chk(s_addr_rx == {a, 1'b1}, "R3 address byte", int'(s_addr_rx), int'({a, 1'b1}));
      chk(s_last_rises == 10 + 9 * n_exp, "R6/R7 SCL rising edges",
          s_last_rises, 10 + 9 * n_exp);
      chk(idle && !scl_oe && !sda_oe, "R6 idle after STOP", int'(idle), 1);
      chk(s_acks == (n_exp > 0 ? n_exp - 1 : 0) && s_nacks == (n_exp > 0 ? 1 : 0),
          "R5 acknowledge pattern", s_acks, (n_exp > 0 ? n_exp - 1 : 0));
      chk(nack_err == !pres, "R10 address nack flag", int'(nack_err), int'(!pres));
      if (n_exp > 0)
         chk(s_hi_last == 2 * (div + 1), "R12 SCL high length", s_hi_last, 2 * (div + 1));
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(4 * 190000);
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   // ---------------- main ----------------
   initial begin
      int seed_v, st0;
      seed_v = int'($urandom(32'd4711));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(idle && !rx_ready && !nack_err && !scl_oe && !sda_oe, "R1 reset state",
          int'({idle, rx_ready, nack_err, scl_oe, sda_oe}), 16);

      // R2: command without start bit is ignored
      st0 = s_starts;
      clk_div = DIV_W'(1);
      cmd_valid = 1'b1; cmd_stop = 1'b1; cmd_nbytes = 8'd3; cmd_addr = 7'h21;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_stop = 1'b0;
      repeat (20) @(negedge clk);
      chk(idle && !scl_oe && !sda_oe && s_starts == st0, "R2 no-start command ignored",
          s_starts, st0);

      // R7: zero-byte read
      tx_base = 8'hC3;
      run_read(7'h2A, 0, 1'b1, 1'b1, 2, 0);
      // R10: address not acknowledged
      run_read(7'h11, 3, 1'b0, 1'b1, 1, 0);
      // R10 clear, normal read
      tx_base = 8'h5A;
      run_read(7'h50, 3, 1'b1, 1'b1, 1, 0);
      // R5 single byte: only a NACK
      tx_base = 8'h96;
      run_read(7'h7F, 1, 1'b1, 1'b1, 3, 0);
      // R8 full holding register stretches SCL
      tx_base = 8'h3C;
      run_read(7'h33, 3, 1'b1, 1'b1, 2, 150);
      // R11 no stop: park then close
      tx_base = 8'hE1;
      run_read(7'h0F, 2, 1'b1, 1'b0, 1, 0);

      // constrained random reads
      for (int i = 0; i < 10; i++) begin
         tx_base = 8'($urandom);
         run_read(7'($urandom), int'($urandom_range(1, 5)), 1'b1, 1'b1,
                  int'($urandom_range(1, 4)), 0);
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule